// File: doc/BRIEF.md
# Instruction fetch break sequencer

This block sits beside a processor pipeline and raises a break interrupt request when an instruction at a programmed 16-bit instruction address actually executes. Each fetch bus cycle brings in one 32-bit word that holds two 16-bit instructions. Every channel's address compare is applied to both halfwords separately. The match result is stored as a tag beside the instruction in a two-entry queue, one entry per halfword. A branch or interrupt redirect empties the queue, so instructions fetched by overrun and then thrown away can never trigger a break.

When an instruction reaches the execute point, the block reads the tag at the head of the queue. It then issues, or holds back, a break request for each channel. Each channel is programmed to break either before the matched instruction executes or after it completes. A request that falls on an instruction that cannot be interrupted (a delay slot, or the instruction after an interrupt-masking load) is held pending. It is issued at the boundary before the next instruction that can be interrupted.

The output is a registered one-cycle pulse with one flag per channel. The interrupt controller receives the pulse and redirects the pipeline.

Top module: `fetch_break_seq`

## Requirements
- R1: A channel can match only when its master field is 1 (CPU), its kind field is 1 (instruction fetch), its read field is 1 and its size field is 2'b01 (16-bit). Any other setting of these fields never produces a break on that channel.
- R2: In a fetch at word address W, the instruction at W and the instruction at W+2 are compared separately against every channel address. The compare uses address bits 31..1, so bit 0 of the channel address is ignored.
- R3: The instruction at the lower address executes first. A fetch with address bit 1 set loads only the instruction at W+2, so a channel programmed for W cannot match from that fetch.
- R4: A channel in before mode (its after bit is 0) whose matched instruction is presented on ex_valid with ex_noint low raises brk_req, with that channel's flag set in brk_ch, exactly one cycle after that ex_valid.
- R5: A channel in after mode (its after bit is 1) raises no request at its matched instruction's own ex_valid. It raises the request one cycle after the next ex_valid that has ex_noint low.
- R6: A redirect empties the queue. Instructions loaded before the redirect that have not yet executed never cause a break, even if a later ex_valid arrives while the queue is empty.
- R7: A match of either mode on an instruction presented with ex_noint high produces no request in the cycle after it. The request is held and issued one cycle after the next ex_valid with ex_noint low.
- R8: A new pending match is added to the matches already pending and never replaces them. When several channels are due at the same boundary, all of their flags are set in brk_ch in the same pulse.
- R9: When a break is taken before an instruction, any after-mode match on that same instruction is dropped.
- R10: While rst is high and in the cycle after it, brk_req and brk_ch are 0, the queue is empty and nothing is pending.
- R11: brk_ch is all zero whenever brk_req is low, and has at least one bit set whenever brk_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | NCH | Per channel: bus master select, 1 = CPU |
| cfg_fetch | input | NCH | Per channel: cycle kind, 1 = instruction fetch |
| cfg_read | input | NCH | Per channel: direction, 1 = read |
| cfg_size | input | 2*NCH | Per channel: operand size, 2'b01 = 16-bit |
| cfg_after | input | NCH | Per channel: 1 = break after execution, 0 = before |
| cfg_addr | input | NCH*AW | Per channel break address; channel c is bits c*AW upward |
| fetch_valid | input | 1 | A fetch word is loaded into the queue this cycle |
| fetch_addr | input | AW | Fetch address; bit 1 set means start at the second halfword |
| redirect | input | 1 | Branch or interrupt redirect; empties the queue |
| ex_valid | input | 1 | The head instruction reaches the execute point |
| ex_noint | input | 1 | The instruction at the execute point cannot accept interrupts |
| brk_req | output | 1 | Registered one-cycle break request |
| brk_ch | output | NCH | Channels that caused the request; bit 0 is channel A |

## Verification
Fetches are tried at even and odd halfword starts, with matches on the first and on the second halfword, so the tests can tell whether the halfword selection is wrong or the execution order is wrong. Each mode is run on interruptible and non-interruptible instructions, and the after-mode cases check whether the request is tied to the matched instruction or to the next boundary. Redirects placed between a fetch and its execution separate instructions that were discarded from instructions that executed. Combined runs with both channels set, and with mixed modes on one instruction, check that pending matches accumulate and that an after-mode match on a cancelled instruction is dropped. Each qualifier field is also altered one at a time, to show that only the fetch configuration can match.

// File: rtl/fbk_pkg.sv
`timescale 1ns/1ps
package fbk_pkg;
  // operand size encoding of the per-channel bus-cycle setting
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } size_e;

  // one queue slot per halfword of a fetch word
  localparam int SLOTS = 2;
endpackage

// File: rtl/fbk_match.sv
`timescale 1ns/1ps
module fbk_match
  import fbk_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic [NCH-1:0]    cfg_master,
  input  logic [NCH-1:0]    cfg_fetch,
  input  logic [NCH-1:0]    cfg_read,
  input  logic [2*NCH-1:0]  cfg_size,
  input  logic [NCH*AW-1:0] cfg_addr,
  input  logic [AW-1:0]     fetch_addr,
  output logic [NCH-1:0]    tag_lo,
  output logic [NCH-1:0]    tag_hi
);
  // bit 0 takes no part in an instruction address compare
  localparam logic [AW-1:0] HW_MASK = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] addr_lo, addr_hi;
  assign addr_lo = {fetch_addr[AW-1:2], 1'b0, fetch_addr[0]};
  assign addr_hi = {fetch_addr[AW-1:2], 1'b1, fetch_addr[0]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0] ch_addr;
    logic          armed;
    assign ch_addr = cfg_addr[c*AW +: AW];
    assign armed   = cfg_master[c] & cfg_fetch[c] & cfg_read[c] &
                     (cfg_size[2*c +: 2] == SZ_WORD);
    assign tag_lo[c] = armed & (((ch_addr ^ addr_lo) & HW_MASK) == '0);
    assign tag_hi[c] = armed & (((ch_addr ^ addr_hi) & HW_MASK) == '0);
  end
endmodule

// File: rtl/fbk_queue.sv
`timescale 1ns/1ps
module fbk_queue
  import fbk_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           load,
  input  logic           start_hi,
  input  logic [NCH-1:0] tag_lo,
  input  logic [NCH-1:0] tag_hi,
  input  logic           pop,
  output logic           head_v,
  output logic [NCH-1:0] head_tag
);
  logic [SLOTS-1:0] v_q;
  logic [NCH-1:0]   tag_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q      <= '0;
      tag_q[0] <= '0;
      tag_q[1] <= '0;
    end else if (flush) begin
      v_q <= '0;
    end else if (load) begin
      if (start_hi) begin
        v_q      <= 2'b01;
        tag_q[0] <= tag_hi;
      end else begin
        v_q      <= 2'b11;
        tag_q[0] <= tag_lo;
        tag_q[1] <= tag_hi;
      end
    end else if (pop) begin
      v_q      <= {1'b0, v_q[1]};
      tag_q[0] <= tag_q[1];
    end
  end

  assign head_v   = v_q[0];
  assign head_tag = tag_q[0];
endmodule

// File: rtl/fbk_pend.sv
`timescale 1ns/1ps
module fbk_pend #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ex_valid,
  input  logic           ex_noint,
  input  logic           head_v,
  input  logic [NCH-1:0] head_tag,
  input  logic [NCH-1:0] cfg_after,
  output logic           brk_req,
  output logic [NCH-1:0] brk_ch
);
  logic [NCH-1:0] pend_q, before_m, after_m, fire;

  assign before_m = head_v ? (head_tag & ~cfg_after) : '0;
  assign after_m  = head_v ? (head_tag &  cfg_after) : '0;
  assign fire     = pend_q | before_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      brk_req <= 1'b0;
      brk_ch  <= '0;
    end else begin
      brk_req <= 1'b0;
      brk_ch  <= '0;
      if (ex_valid) begin
        if (ex_noint) begin
          pend_q <= pend_q | before_m | after_m;
        end else if (fire != '0) begin
          brk_req <= 1'b1;
          brk_ch  <= fire;
          pend_q  <= '0;        // the cancelled instruction's after-matches go
        end else begin
          pend_q  <= after_m;
        end
      end
    end
  end
endmodule

// File: rtl/fetch_break_seq.sv
`timescale 1ns/1ps
module fetch_break_seq #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    cfg_master,
  input  logic [NCH-1:0]    cfg_fetch,
  input  logic [NCH-1:0]    cfg_read,
  input  logic [2*NCH-1:0]  cfg_size,
  input  logic [NCH-1:0]    cfg_after,
  input  logic [NCH*AW-1:0] cfg_addr,
  input  logic              fetch_valid,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              redirect,
  input  logic              ex_valid,
  input  logic              ex_noint,
  output logic              brk_req,
  output logic [NCH-1:0]    brk_ch
);
  logic [NCH-1:0] tag_lo, tag_hi, head_tag;
  logic           head_v;

  fbk_match #(.NCH(NCH), .AW(AW)) u_match (
    .cfg_master (cfg_master),
    .cfg_fetch  (cfg_fetch),
    .cfg_read   (cfg_read),
    .cfg_size   (cfg_size),
    .cfg_addr   (cfg_addr),
    .fetch_addr (fetch_addr),
    .tag_lo     (tag_lo),
    .tag_hi     (tag_hi)
  );

  fbk_queue #(.NCH(NCH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (redirect),
    .load     (fetch_valid),
    .start_hi (fetch_addr[1]),
    .tag_lo   (tag_lo),
    .tag_hi   (tag_hi),
    .pop      (ex_valid),
    .head_v   (head_v),
    .head_tag (head_tag)
  );

  fbk_pend #(.NCH(NCH)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .ex_valid  (ex_valid),
    .ex_noint  (ex_noint),
    .head_v    (head_v),
    .head_tag  (head_tag),
    .cfg_after (cfg_after),
    .brk_req   (brk_req),
    .brk_ch    (brk_ch)
  );
endmodule

// File: rtl/fbk_chk.sv
`timescale 1ns/1ps
module fbk_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           redirect,
  input logic           ex_valid,
  input logic           ex_noint,
  input logic           head_v,
  input logic           brk_req,
  input logic [NCH-1:0] brk_ch
);
  a_r11_idle_no_flags: assert property (@(posedge clk) disable iff (rst)
    !brk_req |-> (brk_ch == '0));

  a_r11_req_has_flag: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (brk_ch != '0));

  a_r4_req_at_boundary: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> ($past(ex_valid) && !$past(ex_noint)));

  a_r7_noint_holds: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_noint) |=> !brk_req);

  a_r6_redirect_empties: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !head_v);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!brk_req && brk_ch == '0 && !head_v));
endmodule

bind fetch_break_seq fbk_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .redirect (redirect),
  .ex_valid (ex_valid),
  .ex_noint (ex_noint),
  .head_v   (head_v),
  .brk_req  (brk_req),
  .brk_ch   (brk_ch)
);

// File: tb/sim_fetch_break_seq.sv
`timescale 1ns/1ps
module sim_fetch_break_seq;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    cfg_master, cfg_fetch, cfg_read, cfg_after;
  logic [2*NCH-1:0]  cfg_size;
  logic [NCH*AW-1:0] cfg_addr;
  logic              fetch_valid = 1'b0;
  logic [AW-1:0]     fetch_addr  = '0;
  logic              redirect    = 1'b0;
  logic              ex_valid    = 1'b0;
  logic              ex_noint    = 1'b0;
  logic              brk_req;
  logic [NCH-1:0]    brk_ch;

  int  n_vec  = 0;
  int  n_miss = 0;
  bit  done   = 1'b0;

  logic [NCH-1:0] exp_q [$];
  string          rq_q  [$];

  always #4 clk = ~clk;   // 125 MHz

  fetch_break_seq #(.NCH(NCH), .AW(AW)) u0 (.*);

  // driver: one call is one clock cycle, with the output expected after it
  task automatic step(input logic fv, input logic [AW-1:0] fa, input logic ex,
                      input logic ni, input logic fl, input logic [NCH-1:0] exp,
                      input string rq);
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa; ex_valid = ex; ex_noint = ni; redirect = fl;
    exp_q.push_back(exp);
    rq_q.push_back(rq);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input string rq);
    step(1'b1, a, 1'b0, 1'b0, 1'b0, '0, rq);
  endtask
  task automatic exe(input logic ni, input logic [NCH-1:0] exp, input string rq);
    step(1'b0, '0, 1'b1, ni, 1'b0, exp, rq);
  endtask
  task automatic flush(input string rq);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, '0, rq);
  endtask
  task automatic idle(input string rq);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, rq);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
  endtask

  // monitor: sample just after each edge, compare with the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [NCH-1:0] e;
        string          r;
        e = exp_q.pop_front();
        r = rq_q.pop_front();
        n_vec++;
        if (brk_req !== (e != '0) || brk_ch !== e) begin
          n_miss++;
          $display("FAIL %s: brk_req=%0b brk_ch=%b expected brk_req=%0b brk_ch=%b",
                   r, brk_req, brk_ch, (e != '0), e);
        end
      end else if (!rst && brk_req !== 1'b0) begin
        n_vec++;
        n_miss++;
        $display("FAIL R11: brk_req=%0b brk_ch=%b expected brk_req=0 brk_ch=00",
                 brk_req, brk_ch);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // channel A (bit 0): 0x1000 before; channel B (bit 1): 0x2002 after
    cfg_master = 2'b11; cfg_fetch = 2'b11; cfg_read = 2'b11;
    cfg_size   = {2'b01, 2'b01};
    cfg_after  = 2'b10;
    cfg_addr   = {32'h0000_2002, 32'h0000_1000};
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle("R10");                          // reset state

    // R4 before mode on the first halfword, then R11 quiet cycle
    fetch(32'h1000, "R2");
    exe(1'b0, 2'b01, "R4");
    flush("R11");

    // R5 after mode on the second halfword, fires at the next boundary
    fetch(32'h2000, "R5");
    exe(1'b0, 2'b00, "R5");
    step(1'b1, 32'h2004, 1'b1, 1'b0, 1'b0, 2'b00, "R5");
    exe(1'b0, 2'b10, "R5");
    flush("R5");

    // R6 overrun fetch discarded by a redirect
    fetch(32'h1000, "R6");
    flush("R6");
    exe(1'b0, 2'b00, "R6");
    exe(1'b0, 2'b00, "R6");

    // R2 bit 0 of the channel address ignored
    cfg_addr[31:0] = 32'h1001;
    idle("R2");
    fetch(32'h1000, "R2");
    exe(1'b0, 2'b01, "R2");
    flush("R2");

    // R3 odd start drops the lower-address instruction
    cfg_addr[31:0] = 32'h1000;
    fetch(32'h1002, "R3");
    exe(1'b0, 2'b00, "R3");
    exe(1'b0, 2'b00, "R3");
    cfg_addr[31:0] = 32'h1002;
    fetch(32'h1002, "R3");
    exe(1'b0, 2'b01, "R3");
    flush("R3");
    // R3 order: lower address first, match on the second
    fetch(32'h1000, "R3");
    exe(1'b0, 2'b00, "R3");
    exe(1'b0, 2'b01, "R3");
    flush("R3");
    cfg_addr[31:0] = 32'h1000;

    // R1 each qualifier altered on its own
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: cfg_master[0] = 1'b0;
        1: cfg_fetch[0]  = 1'b0;
        2: cfg_read[0]   = 1'b0;
        default: cfg_size[1:0] = 2'b10;
      endcase
      fetch(32'h1000, "R1");
      exe(1'b0, 2'b00, "R1");
      flush("R1");
      cfg_master = 2'b11; cfg_fetch = 2'b11; cfg_read = 2'b11;
      cfg_size   = {2'b01, 2'b01};
    end

    // R7 before-match on a non-interruptible instruction is postponed
    fetch(32'h1000, "R7");
    exe(1'b1, 2'b00, "R7");
    step(1'b1, 32'h1004, 1'b1, 1'b1, 1'b0, 2'b00, "R7");
    exe(1'b0, 2'b01, "R7");
    flush("R7");

    // R8 accumulation: A pending, then B after-match joins it
    cfg_addr[63:32] = 32'h1002;
    fetch(32'h1000, "R8");
    exe(1'b1, 2'b00, "R8");
    step(1'b1, 32'h1004, 1'b1, 1'b1, 1'b0, 2'b00, "R8");
    exe(1'b0, 2'b11, "R8");
    flush("R8");

    // R8 both channels before mode on one instruction
    cfg_addr[63:32] = 32'h1000;
    cfg_after = 2'b00;
    fetch(32'h1000, "R8");
    exe(1'b0, 2'b11, "R8");
    flush("R8");

    // R9 break before the instruction drops its own after-match
    cfg_after = 2'b10;
    fetch(32'h1000, "R9");
    exe(1'b0, 2'b01, "R9");
    exe(1'b0, 2'b00, "R9");
    exe(1'b0, 2'b00, "R9");
    idle("R9");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule